// File: doc/BRIEF.md
# Configurable Serial Transceiver Core

This block is a serial transmitter and receiver driven by a narrow byte-wide host write port. Each frame begins with a low start bit. The data bits follow, least significant first, and one or two high stop bits close the frame. The line rests high between frames. Configuration fields set the data length (5, 6, 7, 8 or 9 bits), the number of stop bits, and whether the link runs asynchronously or as a synchronous master that drives its own shift clock. A 12-bit divisor sets the bit rate.

In asynchronous mode each bit lasts sixteen divider periods. The receiver re-times the line and samples in the middle of each bit. In synchronous mode the core drives a shift clock whose period is two divider periods. A polarity field chooses which clock edge changes the transmit line and which edge samples the receive line.

The host writes four addresses:

- 0: divisor low byte.
- 1: shared address. Bit 7 of the written byte chooses the target:
  - bit 7 = 0: the low nibble becomes divisor bits 11:8.
  - bit 7 = 1: the byte updates the control fields. Bit 6 is synchronous mode, bit 3 is two stop bits, bits 2:1 are length code bits 1:0, and bit 0 is clock polarity.
- 2: extension. Bit 2 is length code bit 2, and bit 0 is the ninth transmit bit.
- 3: writing this address starts a frame carrying the written byte.

Top module: `usart_core`

## Requirements
- R1: After reset the transmit line is high, the shift clock is low, busy and receive-valid are low, the divisor is 0 and the configuration is asynchronous, one stop bit, length code 000.
- R2: In asynchronous mode the transmit line goes low in the cycle after the frame-start write. Each bit, including start and stop bits, lasts exactly 16×(divisor+1) clocks, and data goes out least significant bit first.
- R3: Length code {ext bit 2, ctrl bits 2:1} selects the data length: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9 bits. In 9-bit mode the last data bit sent is ext bit 0.
- R4: Length codes 100, 101 and 110 behave as 8-bit frames.
- R5: Ctrl bit 3 = 0 gives one stop bit and 1 gives two. Busy is high from the cycle after the start write through the last stop bit, and it falls exactly at the frame's end.
- R6: A write to address 1 with bit 7 = 1 changes only the control fields. A write with bit 7 = 0 changes only divisor bits 11:8.
- R7: The divisor is 12 bits wide. Its bits 11:8 come from bits 3:0 of the address-1 write, and the written bits 6:4 are ignored.
- R8: In synchronous mode the shift clock has a period of 2×(divisor+1) clocks. In asynchronous mode it is held low.
- R9: In synchronous mode with polarity 0, the transmit line changes only together with a rising shift-clock edge and the receive line is sampled on falling edges. Polarity 1 swaps the two edges.
- R10: The asynchronous receiver samples the middle of each bit. It presents the received data right-aligned on rx_data, with the ninth bit on rx_bit9, and it raises rx_valid for exactly one cycle.
- R11: rx_frame_err is set with the received word when the first stop bit is sampled low, and it is cleared otherwise.
- R12: A frame-start write while busy is ignored: the current frame is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 8 | Host write data |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| sclk_o | output | 1 | Shift clock in synchronous mode |
| tx_busy | output | 1 | Transmit frame in progress |
| rx_valid | output | 1 | One-cycle pulse when a word is received |
| rx_data | output | 8 | Received data bits 7:0 |
| rx_bit9 | output | 1 | Received ninth data bit |
| rx_frame_err | output | 1 | First stop bit of the received word was low |

## Verification
The transmit line and busy both change one clock after the write that starts a frame. Every later bit boundary then falls a whole multiple of 16×(divisor+1) clocks after that edge. The bench therefore counts falling clock edges from the write and samples the line in the centre of each bit. It reads busy on the falling edges just before and just after the computed frame end.

Received words arrive a few clocks after the middle of the first stop bit, because of the two-stage line re-timer and the register that holds the word. The bench waits for the rx_valid pulse inside a bounded window and reads the word on that pulse. In synchronous mode the transmit line and the shift clock change on the same edge. The bench compares both on every falling edge to confirm that the pairing matches the polarity.

// File: rtl/usart_pkg.sv
package usart_pkg;

  localparam int DATA_W = 9;

  localparam logic [1:0] ADDR_DIV_LO = 2'd0;
  localparam logic [1:0] ADDR_SHARED = 2'd1;
  localparam logic [1:0] ADDR_EXT    = 2'd2;
  localparam logic [1:0] ADDR_TXDATA = 2'd3;

  typedef struct packed {
    logic       sync;
    logic       stop2;
    logic [2:0] size;
    logic       pol;
    logic       tx9;
  } cfg_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_STOP1, TX_STOP2
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_t;

  // Reserved codes fall back to eight bits.
  function automatic logic [3:0] data_len(input logic [2:0] code);
    case (code)
      3'b000:  data_len = 4'd5;
      3'b001:  data_len = 4'd6;
      3'b010:  data_len = 4'd7;
      3'b111:  data_len = 4'd9;
      default: data_len = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/usart_regs.sv
module usart_regs import usart_pkg::*; #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [DIV_W-1:0] div_o,
  output cfg_t             cfg_o,
  output logic             tx_start_o,
  output logic [7:0]       tx_byte_o
);

  localparam int HI_W = DIV_W - 8;

  logic [7:0]      div_lo_q, div_lo_d;
  logic [HI_W-1:0] div_hi_q, div_hi_d;
  cfg_t            cfg_q, cfg_d;

  wire unused_wr_bits = ^wr_data[5:4];

  always_comb begin
    div_lo_d = div_lo_q;
    div_hi_d = div_hi_q;
    cfg_d    = cfg_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_DIV_LO: div_lo_d = wr_data;
        ADDR_SHARED: begin
          if (wr_data[7]) begin
            cfg_d.sync      = wr_data[6];
            cfg_d.stop2     = wr_data[3];
            cfg_d.size[1:0] = wr_data[2:1];
            cfg_d.pol       = wr_data[0];
          end else begin
            div_hi_d = wr_data[HI_W-1:0];
          end
        end
        ADDR_EXT: begin
          cfg_d.size[2] = wr_data[2];
          cfg_d.tx9     = wr_data[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      cfg_q    <= '0;
    end else begin
      div_lo_q <= div_lo_d;
      div_hi_q <= div_hi_d;
      cfg_q    <= cfg_d;
    end
  end

  assign div_o      = {div_hi_q, div_lo_q};
  assign cfg_o      = cfg_q;
  assign tx_start_o = wr_en && (wr_addr == ADDR_TXDATA);
  assign tx_byte_o  = wr_data;

endmodule

// File: rtl/usart_baud.sv
module usart_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = en && (cnt_q == '0);
    if (clr)          cnt_d = div_i;
    else if (!en)     cnt_d = cnt_q;
    else if (tick_o)  cnt_d = div_i;
    else              cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/usart_tx.sv
module usart_tx import usart_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       ninth_i,
  input  logic [3:0] len_i,
  input  logic       stop2_i,
  input  logic       sync_i,
  input  logic       tick_i,
  input  logic       drive_i,
  output logic       bclr_o,
  output logic       tx_o,
  output logic       busy_o
);

  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  tx_state_t         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [3:0]        len_q, len_d;
  logic              stop2_q, stop2_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic              tx_q, tx_d;
  logic              bit_end;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    stop2_d = stop2_q;
    sub_d   = sub_q;
    bclr_o  = 1'b0;
    bit_end = sync_i ? drive_i : (tick_i && (sub_q == SUB_LAST));

    if ((st_q != TX_IDLE) && !sync_i && tick_i)
      sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);

    case (st_q)
      TX_IDLE: begin
        if (start_i) begin
          sh_d    = {ninth_i, byte_i};
          len_d   = len_i;
          stop2_d = stop2_i;
          sub_d   = '0;
          bclr_o  = 1'b1;
          st_d    = sync_i ? TX_WAIT : TX_START;
        end
      end
      TX_WAIT: if (drive_i) st_d = TX_START;
      TX_START: begin
        if (bit_end) begin
          st_d  = TX_DATA;
          cnt_d = '0;
        end
      end
      TX_DATA: begin
        if (bit_end) begin
          sh_d  = sh_q >> 1;
          cnt_d = cnt_q + 4'd1;
          if (cnt_q == len_q - 4'd1) st_d = TX_STOP1;
        end
      end
      TX_STOP1: if (bit_end) st_d = stop2_q ? TX_STOP2 : TX_IDLE;
      TX_STOP2: if (bit_end) st_d = TX_IDLE;
      default:  st_d = TX_IDLE;
    endcase

    if (st_d == TX_START)     tx_d = 1'b0;
    else if (st_d == TX_DATA) tx_d = sh_d[0];
    else                      tx_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      len_q   <= 4'd5;
      stop2_q <= 1'b0;
      sub_q   <= '0;
      tx_q    <= 1'b1;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      stop2_q <= stop2_d;
      sub_q   <= sub_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = (st_q != TX_IDLE);

endmodule

// File: rtl/usart_rx.sv
module usart_rx import usart_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       sync_i,
  input  logic [3:0] len_i,
  input  logic       tick_i,
  input  logic       samp_i,
  output logic       bclr_o,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       ferr_o
);

  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  rx_state_t         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] aligned;
  logic [3:0]        cnt_q, cnt_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic              s1_q, s2_q, s3_q;
  logic              valid_d, ferr_q, ferr_d, bit9_q, bit9_d;
  logic [7:0]        data_q, data_d;
  logic              samp;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    sub_d   = sub_q;
    valid_d = 1'b0;
    ferr_d  = ferr_q;
    bit9_d  = bit9_q;
    data_d  = data_q;
    bclr_o  = 1'b0;
    samp    = sync_i ? samp_i : (tick_i && (sub_q == SUB_MID));
    aligned = sh_q >> (4'(DATA_W) - len_i);

    if ((st_q != RX_IDLE) && !sync_i && tick_i)
      sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);

    case (st_q)
      RX_IDLE: begin
        if (!sync_i) begin
          if (s3_q && !s2_q) begin
            st_d   = RX_START;
            sub_d  = '0;
            bclr_o = 1'b1;
          end
        end else if (samp_i && !s2_q) begin
          st_d  = RX_DATA;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (samp) begin
          st_d  = s2_q ? RX_IDLE : RX_DATA;
          cnt_d = '0;
        end
      end
      RX_DATA: begin
        if (samp) begin
          sh_d  = {s2_q, sh_q[DATA_W-1:1]};
          cnt_d = cnt_q + 4'd1;
          if (cnt_q == len_i - 4'd1) st_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (samp) begin
          st_d    = RX_IDLE;
          valid_d = 1'b1;
          ferr_d  = !s2_q;
          data_d  = aligned[7:0];
          bit9_d  = aligned[8];
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      sub_q   <= '0;
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      s3_q    <= 1'b1;
      valid_o <= 1'b0;
      ferr_q  <= 1'b0;
      bit9_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      sub_q   <= sub_d;
      s1_q    <= rx_i;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      valid_o <= valid_d;
      ferr_q  <= ferr_d;
      bit9_q  <= bit9_d;
      data_q  <= data_d;
    end
  end

  assign data_o = data_q;
  assign bit9_o = bit9_q;
  assign ferr_o = ferr_q;

endmodule

// File: rtl/usart_core.sv
module usart_core import usart_pkg::*; #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       sclk_o,
  output logic       tx_busy,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_frame_err
);

  cfg_t             cfg;
  logic [DIV_W-1:0] div;
  logic             tx_start;
  logic [7:0]       tx_byte;
  logic [3:0]       len;
  logic             tx_tick, tx_clr, rx_tick, rx_clr, sc_tick;
  logic             sclk_q, sclk_d;
  logic             rise_ev, fall_ev, drive_ev, samp_ev;
  logic             sync_mode, clk_pol;

  assign sync_mode = cfg.sync;
  assign clk_pol   = cfg.pol;
  assign len       = data_len(cfg.size);

  usart_regs #(.DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_o(div), .cfg_o(cfg),
    .tx_start_o(tx_start), .tx_byte_o(tx_byte)
  );

  usart_baud #(.DIV_W(DIV_W)) i_tx_baud (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(tx_clr),
    .div_i(div), .tick_o(tx_tick)
  );

  usart_baud #(.DIV_W(DIV_W)) i_rx_baud (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .clr(rx_clr),
    .div_i(div), .tick_o(rx_tick)
  );

  usart_baud #(.DIV_W(DIV_W)) i_sclk_baud (
    .clk(clk), .rst_n(rst_n), .en(sync_mode), .clr(!sync_mode),
    .div_i(div), .tick_o(sc_tick)
  );

  always_comb begin
    rise_ev  = sc_tick && !sclk_q;
    fall_ev  = sc_tick && sclk_q;
    drive_ev = clk_pol ? fall_ev : rise_ev;
    samp_ev  = clk_pol ? rise_ev : fall_ev;
    sclk_d   = sync_mode ? (sc_tick ? !sclk_q : sclk_q) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

  assign sclk_o = sclk_q;

  usart_tx #(.OVS(OVS)) i_tx (
    .clk(clk), .rst_n(rst_n), .start_i(tx_start), .byte_i(tx_byte),
    .ninth_i(cfg.tx9), .len_i(len), .stop2_i(cfg.stop2),
    .sync_i(sync_mode), .tick_i(tx_tick), .drive_i(drive_ev),
    .bclr_o(tx_clr), .tx_o(tx_o), .busy_o(tx_busy)
  );

  usart_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .sync_i(sync_mode),
    .len_i(len), .tick_i(rx_tick), .samp_i(samp_ev),
    .bclr_o(rx_clr), .valid_o(rx_valid), .data_o(rx_data),
    .bit9_o(rx_bit9), .ferr_o(rx_frame_err)
  );

endmodule

// File: rtl/usart_core_chk.sv
module usart_core_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_o,
  input logic sclk_o,
  input logic tx_busy,
  input logic rx_valid,
  input logic sync_mode,
  input logic clk_pol
);

  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);

  // R2
  async_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && $rose(tx_busy)) |-> !tx_o);

  // R5
  frame_ends_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> tx_o);

  // R8
  sclk_quiet_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !sclk_o);

  // R9
  pol0_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $past(sync_mode) && !clk_pol && !$past(clk_pol) && !$stable(tx_o))
      |-> $rose(sclk_o));

  // R9
  pol1_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $past(sync_mode) && clk_pol && $past(clk_pol) && !$stable(tx_o))
      |-> $fell(sclk_o));

  // R10
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

bind usart_core usart_core_chk i_usart_core_chk (
  .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .sclk_o(sclk_o),
  .tx_busy(tx_busy), .rx_valid(rx_valid),
  .sync_mode(sync_mode), .clk_pol(clk_pol)
);

// File: tb/test_usart_core.sv
module test_usart_core;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       rx_drv;
  logic       loop;
  logic       rx_line;
  logic       tx_o, sclk_o, tx_busy, rx_valid, rx_bit9, rx_frame_err;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       cap_got;
  logic [7:0] cap_data;
  logic       cap_b9, cap_fe;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_line = loop ? tx_o : rx_drv;

  usart_core i_usart_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_i(rx_line), .tx_o(tx_o), .sclk_o(sclk_o),
    .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_frame_err(rx_frame_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rx(input int limit);
    cap_got = 1'b0;
    for (int w = 0; w < limit && !cap_got; w++) begin
      @(negedge clk);
      if (rx_valid) begin
        cap_got = 1'b1; cap_data = rx_data; cap_b9 = rx_bit9; cap_fe = rx_frame_err;
      end
    end
  endtask

  // Samples each bit at its centre, counted from the start-write edge.
  task automatic tx_frame(input logic [8:0] val, input int nbits, input int nstop,
                          input int B, input bit poke, input string req);
    int t, total, bad, first_k;
    logic exp_b, first_act, first_exp;
    total = 1 + nbits + nstop;
    bad = 0; first_k = -1; first_act = 1'b0; first_exp = 1'b0;
    wr(2'd3, val[7:0]);
    t = 1;
    if (poke) begin
      wr(2'd3, ~val[7:0]);  // R12: ignored while busy
      t = 3;
    end
    for (int k = 0; k < total; k++) begin
      int target;
      target = k * B + B / 2;
      repeat (target - t) @(negedge clk);
      t = target;
      if (k == 0)          exp_b = 1'b0;
      else if (k <= nbits) exp_b = val[k-1];
      else                 exp_b = 1'b1;
      if (tx_o !== exp_b) begin
        bad++;
        if (first_k < 0) begin first_k = k; first_act = tx_o; first_exp = exp_b; end
      end
    end
    check(bad == 0, {req, " frame bits"}, {first_k, 3'b0, first_act}, {first_k, 3'b0, first_exp});
    repeat (total * B - t) @(negedge clk);
    check(tx_busy === 1'b1, "R5 busy through last stop bit", tx_busy, 1);
    @(negedge clk);
    check(tx_busy === 1'b0 && tx_o === 1'b1, "R5 busy falls at frame end", {tx_busy, tx_o}, 1);
    if (poke) begin
      repeat (2 * B) @(negedge clk);
      check(tx_busy === 1'b0 && tx_o === 1'b1, "R12 no second frame", {tx_busy, tx_o}, 1);
    end
  endtask

  task automatic rx_frame(input logic [8:0] val, input int nbits, input logic stopv, input int B);
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (B) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rx_drv = val[i];
      repeat (B) @(negedge clk);
    end
    rx_drv = stopv;
    wait_rx(2 * B);
    rx_drv = 1'b1;
    repeat (2 * B) @(negedge clk);
  endtask

  task automatic t_reset;
    check(tx_o === 1'b1 && sclk_o === 1'b0, "R1 idle lines", {tx_o, sclk_o}, 2);
    check(tx_busy === 1'b0 && rx_valid === 1'b0, "R1 idle flags", {tx_busy, rx_valid}, 0);
    // R1 default config: divisor 0 (16 clocks per bit), 5 data bits, 1 stop
    tx_frame(9'h015, 5, 1, 16, 1'b0, "R1 R2 default");
  endtask

  task automatic t_async_lengths;
    wr(2'd0, 8'd2);
    wr(2'd1, 8'h86);                     // R6: control write keeps divisor 2
    tx_frame(9'h0A5, 8, 1, 48, 1'b1, "R2 R6 R12 8-bit");
    wr(2'd1, 8'h8A);                     // 6 bits, 2 stops
    tx_frame(9'h02D, 6, 2, 48, 1'b0, "R5 two stops");
    wr(2'd1, 8'h00);                     // R6: divisor-high write, control kept
    tx_frame(9'h03F, 6, 2, 48, 1'b0, "R6 control unchanged");
    wr(2'd1, 8'h84);                     // R3 code 010 -> 7 bits
    tx_frame(9'h055, 7, 1, 48, 1'b0, "R3 7-bit");
    wr(2'd2, 8'h05); wr(2'd1, 8'h86);    // R3 code 111 -> 9 bits, ninth=1
    tx_frame(9'h13C, 9, 1, 48, 1'b0, "R3 9-bit");
    wr(2'd1, 8'h80);                     // R4 code 100
    tx_frame(9'h0C3, 8, 1, 48, 1'b0, "R4 code 100");
    wr(2'd1, 8'h84);                     // R4 code 110
    tx_frame(9'h096, 8, 1, 48, 1'b0, "R4 code 110");
  endtask

  task automatic t_big_divisor;
    wr(2'd2, 8'h00); wr(2'd1, 8'h86);
    wr(2'd0, 8'h00); wr(2'd1, 8'h71);    // R7: high nibble 1, bits 6:4 ignored
    tx_frame(9'h081, 8, 1, 16 * 257, 1'b0, "R7 divisor 256");
    wr(2'd1, 8'h00); wr(2'd0, 8'd2);
  endtask

  task automatic t_rx_async;
    loop = 1'b1;
    wr(2'd2, 8'h05); wr(2'd1, 8'h86);    // 9-bit loopback
    wr(2'd3, 8'h3C);
    wait_rx(13 * 48);
    check(cap_got && cap_data == 8'h3C && cap_b9 == 1'b1 && !cap_fe, "R10 R3 9-bit loopback",
          {cap_got, cap_fe, cap_b9, cap_data}, {3'b101, 8'h3C});
    loop = 1'b0;
    wr(2'd2, 8'h00);
    repeat (100) @(negedge clk);
    rx_frame(9'h05A, 8, 1'b1, 48);
    check(cap_got && cap_data == 8'h5A && !cap_fe, "R10 8-bit receive",
          {cap_got, cap_fe, cap_data}, {2'b10, 8'h5A});
    rx_frame(9'h033, 8, 1'b0, 48);
    check(cap_got && cap_data == 8'h33 && cap_fe, "R11 framing error",
          {cap_got, cap_fe, cap_data}, {2'b11, 8'h33});
    rx_frame(9'h05A, 8, 1'b1, 48);
    check(cap_got && !cap_fe, "R11 error clears", {cap_got, cap_fe}, 2);
    wr(2'd1, 8'h80);
    rx_frame(9'h016, 5, 1'b1, 48);
    check(cap_got && cap_data == 8'h16 && !cap_b9, "R10 5-bit right aligned",
          {cap_got, cap_b9, cap_data}, {2'b10, 8'h16});
    wr(2'd1, 8'h86);
  endtask

  task automatic t_sync(input logic pol);
    int trans, bad, r1, per;
    logic prev_t, prev_s;
    wr(2'd0, 8'd3);
    wr(2'd1, 8'hC6 | {7'd0, pol});
    loop = 1'b1;
    wr(2'd3, 8'hC3);
    trans = 0; bad = 0; r1 = -1; per = 0; cap_got = 1'b0;
    prev_t = tx_o; prev_s = sclk_o;
    for (int c = 0; c < 400 && !cap_got; c++) begin
      @(negedge clk);
      if (tx_o !== prev_t) begin
        trans++;
        if (!(sclk_o !== prev_s && sclk_o === ~pol)) bad++;
      end
      if (sclk_o === 1'b1 && prev_s === 1'b0) begin
        if (r1 >= 0 && per == 0) per = c - r1;
        r1 = c;
      end
      prev_t = tx_o; prev_s = sclk_o;
      if (rx_valid) begin cap_got = 1'b1; cap_data = rx_data; end
    end
    check(cap_got && cap_data == 8'hC3, "R9 sync loopback data", {cap_got, cap_data}, {1'b1, 8'hC3});
    check(bad == 0 && trans > 0, "R9 drive edge pairing", bad, 0);
    check(per == 8, "R8 shift clock period", per, 8);
    loop = 1'b0;
    repeat (100) @(negedge clk);
    wr(2'd1, 8'h86);
    repeat (2) @(negedge clk);
    check(sclk_o === 1'b0, "R8 clock low in async", sclk_o, 0);
    wr(2'd0, 8'd2);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rx_drv = 1'b1; loop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_async_lengths();
    t_big_divisor();
    t_rx_async();
    t_sync(1'b0);
    t_sync(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule